// File: doc/BRIEF.md
# RC6 Block Encryption Round Engine

This block encrypts one 128-bit block with the RC6 cipher (32-bit words, 20 rounds). Software or a separate key-expansion unit prepares the 44 round-key words beforehand. The engine fetches them one per cycle through an indexed read port. It drives a key index, and the key store returns the matching word on `key_data` combinationally in the same cycle. The key schedule and decryption are outside this block.

Plaintext comes in over a valid/ready handshake. The engine takes a block when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high only while the engine is idle, so a second block waits at the source until the current ciphertext has been taken. Ciphertext goes out over a second valid/ready handshake. When `out_ready` is low, `out_valid` and `out_data` hold their values until the sink accepts them.

Each round takes two cycles. In the first cycle the two quadratic mixing terms are computed from B and D and registered, together with the even round key. In the second cycle A and C are updated with data-dependent rotations and the odd round key, and the four words rotate. A two-cycle whitening step runs before the rounds and another runs after them.

Top module: `rc6_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Word packing is little-endian on both data ports. A is bits [31:0], B is [63:32], C is [95:64] and D is [127:96], and byte 0 of each word is its bits [7:0].
- R3: After a block is accepted, `key_idx` steps through 0, 1, 2, ..., 43, one value per cycle. The first value appears in the cycle after acceptance, and `key_data` is used in the same cycle that its index is presented.
- R4: Pre-whitening adds round key 0 to B and round key 1 to D, modulo 2^32.
- R5: Round i (1..20) computes t = rotl(B*(2B+1), 5) and u = rotl(D*(2D+1), 5). It then sets A to rotl(A^t, u mod 32) + S[2i] and C to rotl(C^u, t mod 32) + S[2i+1], and then (A,B,C,D) becomes (B,C,D,A).
- R6: Post-whitening adds round key 42 to A and round key 43 to C.
- R7: `out_valid` rises exactly 44 clock cycles after the acceptance edge. `in_ready` stays low from acceptance until the output handshake, and `in_ready` and `out_valid` are never high together.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. The cycle after the output handshake, `in_ready` is 1 and `out_valid` is 0.
- R9: With all-zero key words expanded by the standard schedule and an all-zero plaintext, the ciphertext is `128'h1ea44898_4edf29c1_78f7b156_36a5c38f`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Plaintext present |
| in_ready | output | 1 | Engine idle and able to take a block |
| in_data | input | 128 | Plaintext, packed as in R2 |
| key_idx | output | 6 | Round-key index being read |
| key_data | input | 32 | Round-key word for `key_idx`, same cycle |
| out_valid | output | 1 | Ciphertext present |
| out_ready | input | 1 | Sink takes the ciphertext |
| out_data | output | 128 | Ciphertext, packed as in R2 |

## Verification
The bound checker checks the handshake and sequencing rules on every cycle. These are the key-index walk from 0 to 43, the exclusion between idle and result, output stability under back-pressure, and the return to idle after the output handshake. The arithmetic itself cannot be seen from the control pins. The mixing terms, the data-dependent rotations, both whitening steps and the word packing are shown only by the bench's scenarios. The bench compares each ciphertext against an independent model, using the zero-key vector and random key sets, while the sink stalls at random.

// File: rtl/rc6_pkg.sv
package rc6_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE_B,
    PH_PRE_D,
    PH_MIX,
    PH_UPD,
    PH_POST_A,
    PH_POST_C,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/rc6_quad.sv
module rc6_quad #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int LGW = $clog2(W);

  logic [W-1:0]   prod;
  logic [2*W-1:0] dbl;

  always_comb begin
    prod = x * {x[W-2:0], 1'b1};
    dbl  = {prod, prod} << LGW;
    y    = dbl[2*W-1:W];
  end
endmodule

// File: rtl/rc6_lane.sv
module rc6_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] mix_self,
  input  logic [W-1:0] mix_other,
  input  logic [W-1:0] rkey,
  output logic [W-1:0] res
);
  localparam int LGW = $clog2(W);

  logic [W-1:0]   xr;
  logic [2*W-1:0] dbl;

  always_comb begin
    xr  = src ^ mix_self;
    dbl = {xr, xr} << mix_other[LGW-1:0];
    res = dbl[2*W-1:W] + rkey;
  end
endmodule

// File: rtl/rc6_engine.sv
module rc6_engine #(
  parameter int W      = 32,
  parameter int ROUNDS = 20
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [4*W-1:0]                      in_data,
  output logic [$clog2(2*ROUNDS+4)-1:0]       key_idx,
  input  logic [W-1:0]                        key_data,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [4*W-1:0]                      out_data
);
  import rc6_pkg::*;

  localparam int NK = 2 * ROUNDS + 4;
  localparam int KW = $clog2(NK);
  localparam int RW = $clog2(ROUNDS + 1);

  phase_e         ph;
  logic [RW-1:0]  rnd;
  logic [W-1:0]   wa, wb, wc, wd;
  logic [W-1:0]   t_q, u_q, kev_q;

  logic [W-1:0] mix_in  [2];
  logic [W-1:0] mix_out [2];
  logic [W-1:0] ln_src  [2];
  logic [W-1:0] ln_self [2];
  logic [W-1:0] ln_oth  [2];
  logic [W-1:0] ln_key  [2];
  logic [W-1:0] ln_res  [2];

  assign mix_in[0] = wb;
  assign mix_in[1] = wd;
  assign ln_src[0] = wa;  assign ln_self[0] = t_q; assign ln_oth[0] = u_q; assign ln_key[0] = kev_q;
  assign ln_src[1] = wc;  assign ln_self[1] = u_q; assign ln_oth[1] = t_q; assign ln_key[1] = key_data;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    rc6_quad #(.W(W)) u_quad (
      .x (mix_in[g]),
      .y (mix_out[g])
    );
    rc6_lane #(.W(W)) u_lane (
      .src       (ln_src[g]),
      .mix_self  (ln_self[g]),
      .mix_other (ln_oth[g]),
      .rkey      (ln_key[g]),
      .res       (ln_res[g])
    );
  end

  always_comb begin
    case (ph)
      PH_PRE_B:  key_idx = KW'(0);
      PH_PRE_D:  key_idx = KW'(1);
      PH_MIX:    key_idx = KW'({rnd, 1'b0});
      PH_UPD:    key_idx = KW'({rnd, 1'b1});
      PH_POST_A: key_idx = KW'(NK - 2);
      PH_POST_C: key_idx = KW'(NK - 1);
      default:   key_idx = '0;
    endcase
  end

  assign in_ready  = (ph == PH_IDLE);
  assign out_valid = (ph == PH_DONE);
  assign out_data  = {wd, wc, wb, wa};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      rnd   <= '0;
      wa    <= '0;
      wb    <= '0;
      wc    <= '0;
      wd    <= '0;
      t_q   <= '0;
      u_q   <= '0;
      kev_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (in_valid) begin
          wa <= in_data[W-1:0];
          wb <= in_data[2*W-1:W];
          wc <= in_data[3*W-1:2*W];
          wd <= in_data[4*W-1:3*W];
          ph <= PH_PRE_B;
        end
        PH_PRE_B: begin
          wb <= wb + key_data;
          ph <= PH_PRE_D;
        end
        PH_PRE_D: begin
          wd  <= wd + key_data;
          rnd <= RW'(1);
          ph  <= PH_MIX;
        end
        PH_MIX: begin
          t_q   <= mix_out[0];
          u_q   <= mix_out[1];
          kev_q <= key_data;
          ph    <= PH_UPD;
        end
        PH_UPD: begin
          wa <= wb;
          wb <= ln_res[1];
          wc <= wd;
          wd <= ln_res[0];
          if (rnd == RW'(ROUNDS)) ph <= PH_POST_A;
          else begin
            rnd <= rnd + RW'(1);
            ph  <= PH_MIX;
          end
        end
        PH_POST_A: begin
          wa <= wa + key_data;
          ph <= PH_POST_C;
        end
        PH_POST_C: begin
          wc <= wc + key_data;
          ph <= PH_DONE;
        end
        PH_DONE: if (out_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rc6_engine_chk.sv
module rc6_engine_chk #(
  parameter int W      = 32,
  parameter int ROUNDS = 20
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_ready,
  input logic [$clog2(2*ROUNDS+4)-1:0] key_idx,
  input logic                          out_valid,
  input logic                          out_ready,
  input logic [4*W-1:0]                out_data
);
  localparam int NK = 2 * ROUNDS + 4;
  localparam int KW = $clog2(NK);

  logic busy;
  assign busy = !in_ready && !out_valid;

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R7

  AST_KEY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && key_idx == KW'(0))); // R3

  AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_idx != KW'(NK - 1)) |=> (busy && key_idx == KW'($past(key_idx) + 1'b1))); // R3

  AST_KEY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_idx == KW'(NK - 1)) |=> out_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

  AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R8

  AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(key_idx) < NK)); // R3
endmodule

bind rc6_engine rc6_engine_chk #(.W(W), .ROUNDS(ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .key_idx   (key_idx),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_rc6_engine.sv
module sim_rc6_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [5:0]   key_idx;
  logic [31:0]  key_data;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;

  logic [31:0]  ks [44];
  logic [127:0] q_exp [$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  rc6_engine u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .key_idx(key_idx), .key_data(key_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  assign key_data = (key_idx < 6'd44) ? ks[key_idx] : 32'hdead_beef;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int s);
    int k = s % 32;
    if (k == 0) return x;
    return (x << k) | (x >> (32 - k));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] p);
    logic [31:0] a, b, c, d, t, u, tmp;
    a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
    b = b + ks[0]; d = d + ks[1];                         // R4
    for (int i = 1; i <= 20; i++) begin                   // R5
      t = rl(b * (2 * b + 1), 5);
      u = rl(d * (2 * d + 1), 5);
      a = rl(a ^ t, int'(u[4:0])) + ks[2*i];
      c = rl(c ^ u, int'(t[4:0])) + ks[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + ks[42]; c = c + ks[43];                       // R6
    return {d, c, b, a};
  endfunction

  task automatic zero_key_schedule();
    logic [31:0] l [4];
    logic [31:0] x, y, sum;
    int i, j;
    for (int k = 0; k < 4; k++) l[k] = '0;
    ks[0] = 32'hB7E15163;
    for (int k = 1; k < 44; k++) ks[k] = ks[k-1] + 32'h9E3779B9;
    x = '0; y = '0; i = 0; j = 0;
    for (int k = 0; k < 132; k++) begin
      x = rl(ks[i] + x + y, 3);
      ks[i] = x;
      sum = x + y;
      y = rl(l[j] + sum, int'(sum[4:0]));
      l[j] = y;
      i = (i + 1) % 44;
      j = (j + 1) % 4;
    end
  endtask

  task automatic send(input logic [127:0] pt);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    q_exp.push_back(model(pt));
    in_valid = 1'b1;
    in_data  = pt;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = '0;
  endtask

  task automatic drain();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  // Monitor / scoreboard
  bit           prev_busy = 0, prev_ov = 0, stalled = 0, released = 0;
  int           exp_idx = 0, busy_cnt = 0;
  logic [127:0] held;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit busy = !in_ready && !out_valid;
      chk(!(in_ready && out_valid), "R7 idle/result exclusive", {in_ready, out_valid}, 0);
      if (busy) begin
        exp_idx = prev_busy ? exp_idx + 1 : 0;
        busy_cnt = prev_busy ? busy_cnt + 1 : 1;
        chk(key_idx == 6'(exp_idx), "R3 key index walk", key_idx, exp_idx);
      end
      if (released) begin
        chk(in_ready && !out_valid, "R8 idle after handshake", {in_ready, out_valid}, 2'b10);
        released = 0;
      end
      if (out_valid && !prev_ov)
        chk(busy_cnt == 44, "R7 latency 44", busy_cnt, 44);
      if (out_valid && stalled)
        chk(out_data == held, "R8 hold under stall", out_data, held);
      if (out_valid) begin
        automatic bit rdy = ($urandom % 3) != 0;
        out_ready = rdy;
        if (rdy) begin
          if (q_exp.size() == 0) chk(0, "R2 unexpected output", out_data, 0);
          else begin
            automatic logic [127:0] e = q_exp.pop_front();
            chk(out_data == e, "R2 R4 R5 R6 ciphertext", out_data, e);
          end
          stalled = 0;
          released = 1;
        end else begin
          stalled = 1;
          held = out_data;
        end
      end else begin
        out_ready = 1'b0;
        stalled = 0;
      end
      prev_busy = busy;
      prev_ov   = out_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 44; k++) ks[k] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 reset state", {in_ready, out_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset release", {in_ready, out_valid}, 2'b10);

    // R9 known-answer vector
    zero_key_schedule();
    send('0);
    drain();
    chk(model('0) == 128'h1ea44898_4edf29c1_78f7b156_36a5c38f, "R9 model self-check",
        model('0), 128'h1ea44898_4edf29c1_78f7b156_36a5c38f);
    send({128{1'b1}});
    send(128'h0f0e0d0c_0b0a0908_07060504_03020100);
    drain();

    // Random round keys, several plaintext patterns
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 44; k++) ks[k] = $urandom;
      send({$urandom, $urandom, $urandom, $urandom});
      send(128'h1);
      send(128'h80000000_00000000_00000000_00000000);
      drain();
    end

    // Round keys zero except whitening words (R4 R6 isolated)
    for (int k = 0; k < 44; k++) ks[k] = '0;
    ks[0] = 32'h11111111; ks[1] = 32'h22222222; ks[42] = 32'h33333333; ks[43] = 32'h44444444;
    send(128'h01234567_89abcdef_fedcba98_76543210);
    drain();

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule